// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sits on the master side of a 32-bit external bus and decides how every transfer it launches comes to an end. Once the requesting core pulses a start strobe, the controller drives the beat address and the byte-lane enables. It then watches four slave responses: an active-low acknowledge, an active-low error acknowledge, a retry request and an active-low burst inhibit. It also runs its own bus monitor. The monitor forces an error ending when no slave answers within a programmable number of cycles.

The outcome goes back to the core on a two-bit status that is valid for exactly one cycle. A retry makes the controller give up the bus and raise a re-arbitration request. The same beat runs again once the grant comes back. A slave that cannot burst can inhibit a four-beat burst, and the controller then finishes the remaining beats as separate single transfers. Before it starts any new transfer, the controller waits until the acknowledge line has been released (high).

The controller has four states. IDLE waits for a start. ACTIVE is a beat on the bus. RELEASE waits for the acknowledge line to go high after a termination. REARB waits for the bus to be granted again. It has eight named transitions:
- LAUNCH: IDLE to ACTIVE, on a start.
- NEXT_BEAT: ACTIVE to ACTIVE, an acknowledged burst beat with more beats to go.
- FINISH: ACTIVE to RELEASE, on the last acknowledge or on an error.
- SPLIT: ACTIVE to RELEASE, an acknowledged beat with more beats that must run as singles.
- BACKOFF: ACTIVE to REARB, on a retry.
- REGRANT: REARB to ACTIVE, on a grant.
- REISSUE: RELEASE to ACTIVE, when single beats remain and the acknowledge line is high.
- QUIET: RELEASE to IDLE, when nothing remains and the acknowledge line is high.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, the outputs are `status_o`=00, `busy_o`=0, `rearb_req_o`=0, `lane_en_o`=0, `tea_drive_o`=0 and `burst_ok_o`=0.
- R2: `start_i`, sampled while idle, captures the address, size, burst request and timeout. The first beat is on the bus (`lane_en_o` non-zero) from the next cycle. A single acknowledge (`ta_n_i`=0) then gives `status_o`=01 for exactly one cycle. A start seen while busy is ignored.
- R3: An error acknowledge (`tea_n_i`=0) during a beat ends the whole transfer with `status_o`=10. It wins over any acknowledge or retry sampled in the same cycle, and no further beats are run.
- R4: The monitor loads the captured timeout L at every beat launch. If no termination arrives, `tea_drive_o` is high on the (L+1)-th cycle of the beat only, and `status_o`=10 follows on the next cycle.
- R5: A retry (`retry_i`=1) wins over an acknowledge and gives `status_o`=11. `rearb_req_o` then stays high until `grant_i`=1. The same beat (same address and beat count) goes back on the bus in the cycle after the grant.
- R6: A burst request with size code 10 (32-bit) runs 4 beats. The address steps by 4 bytes per beat, `beat_cnt_o` counts 0 to 3, and `burst_ok_o` is high during the beats. `status_o`=01 appears once, after the fourth acknowledge.
- R7: A burst request with size code 00 (8-bit) or 01 (16-bit) runs one beat and leaves `burst_ok_o` low.
- R8: If `bi_n_i`=0 is sampled with the acknowledge of burst beat k (k<3), the remaining beats run as single transfers: `burst_ok_o` is low, the address still steps by 4, and the bus is released between beats. `bi_n_i` has no effect on a single transfer.
- R9: After any termination except a retry, no new beat and no return to idle happens while `ta_n_i` is still low. `busy_o` stays high in that time.
- R10: `lane_en_o` bit 3 is the most significant byte lane, and that lane sits at the lowest byte offset. Size 00 enables the one lane at offset addr[1:0]. Size 01 enables two lanes starting at offset {addr[1],0}. Sizes 10 and 11 enable all four lanes. The enables are zero outside a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a transfer (sampled while idle) |
| burst_req_i | input | 1 | Request a 4-beat burst |
| size_i | input | 2 | 00 byte, 01 half-word, 10 word |
| addr_i | input | 32 | Start byte address |
| tmo_load_i | input | 16 | Bus monitor limit in cycles |
| ta_n_i | input | 1 | Transfer acknowledge, active low |
| tea_n_i | input | 1 | Transfer error acknowledge, active low |
| retry_i | input | 1 | Slave asks for a retry |
| bi_n_i | input | 1 | Burst inhibit, active low |
| grant_i | input | 1 | Bus granted again after a retry |
| busy_o | output | 1 | Transfer in progress |
| bus_addr_o | output | 32 | Address of the current beat |
| lane_en_o | output | 4 | Byte-lane enables, bit 3 is the MSB lane |
| beat_cnt_o | output | 2 | Index of the current beat |
| burst_ok_o | output | 1 | Current beat belongs to a running burst |
| tea_drive_o | output | 1 | Monitor asserts the error line |
| rearb_req_o | output | 1 | Request to re-arbitrate for the bus |
| status_o | output | 2 | 00 idle, 01 done, 10 error, 11 retry |

## Verification
The assertions assume that the slave responses only matter during a beat, and that a grant is only looked at while a re-arbitration request is pending. The stimulus holds `ta_n_i`, `tea_n_i` and `bi_n_i` high and `retry_i` low outside the single cycle in which it terminates a beat. The one exception is a deliberate extra cycle of low acknowledge, which checks the release rule. The stimulus only raises `grant_i` while `rearb_req_o` is high. All acknowledge delays are kept below the monitor limit, except in the sweep that checks the timeout itself.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_REARB   = 2'd3
    } btc_state_e;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'b00,
        OUT_DONE  = 2'b01,
        OUT_ERR   = 2'b10,
        OUT_RETRY = 2'b11
    } btc_status_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_ACK   = 2'd1,
        TK_RETRY = 2'd2,
        TK_ERR   = 2'd3
    } term_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/btc_monitor.sv
module btc_monitor #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    input  logic             stop_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;

    // Reload wins over stop so that a beat-to-beat handover restarts the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            run_q <= 1'b1;
        end else if (stop_i) begin
            run_q <= 1'b0;
        end else if (run_q && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

    assert_expire_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> !expired_o);

    assert_no_run_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !load_i) |=> !expired_o);

endmodule

// File: rtl/btc_resolve.sv
module btc_resolve
    import btc_pkg::*;
(
    input  logic       active_i,
    input  logic       ta_n_i,
    input  logic       tea_n_i,
    input  logic       retry_i,
    input  logic       expired_i,
    output term_kind_e kind_o
);

    // Priority: error (external or monitor), then retry, then acknowledge.
    always_comb begin
        kind_o = TK_NONE;
        if (active_i) begin
            if (!tea_n_i || expired_i) begin
                kind_o = TK_ERR;
            end else if (retry_i) begin
                kind_o = TK_RETRY;
            end else if (!ta_n_i) begin
                kind_o = TK_ACK;
            end
        end
    end

endmodule

// File: rtl/btc_lanes.sv
module btc_lanes
    import btc_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [1:0]       size_i,
    input  logic [OFF_W-1:0] offs_i,
    output logic [LANES-1:0] lane_en_o
);

    int first;
    int span;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                first = int'(offs_i);
                span  = 1;
            end
            SZ_HALF: begin
                first = int'(offs_i) & ~1;
                span  = 2;
            end
            default: begin
                first = 0;
                span  = LANES;
            end
        endcase
    end

    // Lane index LANES-1 carries the lowest byte offset (most significant byte).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int POS = LANES - 1 - i;
        assign lane_en_o[i] = active_i && (POS >= first) && (POS < first + span);
    end

    assert_byte_single_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && size_i == SZ_BYTE) |-> ($countones(lane_en_o) == 1));

    assert_half_two_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && size_i == SZ_HALF) |-> ($countones(lane_en_o) == 2));

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import btc_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int TMR_W  = 16,
    parameter  int LANES  = 4,
    parameter  int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              burst_req_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TMR_W-1:0]  tmo_load_i,
    input  logic              ta_n_i,
    input  logic              tea_n_i,
    input  logic              retry_i,
    input  logic              bi_n_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [LANES-1:0]  lane_en_o,
    output logic [BEAT_W-1:0] beat_cnt_o,
    output logic              burst_ok_o,
    output logic              tea_drive_o,
    output logic              rearb_req_o,
    output logic [1:0]        status_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(LANES);

    btc_state_e        state_q, state_d;
    btc_status_e       status_q, status_d;
    term_kind_e        kind;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [TMR_W-1:0]  tmo_q;
    logic [BEAT_W-1:0] beat_q;
    logic              multi_q;
    logic              burst_q;
    logic              pend_q;
    logic              launch;
    logic              expired;
    logic              more;
    logic              active;
    logic [TMR_W-1:0]  load_val;

    assign active   = (state_q == ST_ACTIVE);
    assign more     = multi_q && (beat_q != LAST_BEAT);
    assign load_val = (state_q == ST_IDLE) ? tmo_load_i : tmo_q;

    btc_resolve u_resolve (
        .active_i  (active),
        .ta_n_i    (ta_n_i),
        .tea_n_i   (tea_n_i),
        .retry_i   (retry_i),
        .expired_i (expired),
        .kind_o    (kind)
    );

    btc_monitor #(.TMR_W(TMR_W)) u_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (launch),
        .load_val_i (load_val),
        .stop_i     (kind != TK_NONE),
        .expired_o  (expired)
    );

    btc_lanes #(.LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .size_i    (size_q),
        .offs_i    (addr_q[OFF_W-1:0]),
        .lane_en_o (lane_en_o)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, status and launch decode.
    always_comb begin
        state_d  = state_q;
        status_d = OUT_IDLE;
        launch   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin                      // LAUNCH
                    state_d = ST_ACTIVE;
                    launch  = 1'b1;
                end
            end
            ST_ACTIVE: begin
                unique case (kind)
                    TK_ERR: begin                       // FINISH (error)
                        state_d  = ST_RELEASE;
                        status_d = OUT_ERR;
                    end
                    TK_RETRY: begin                     // BACKOFF
                        state_d  = ST_REARB;
                        status_d = OUT_RETRY;
                    end
                    TK_ACK: begin
                        if (!more) begin                // FINISH (done)
                            state_d  = ST_RELEASE;
                            status_d = OUT_DONE;
                        end else if (burst_q && bi_n_i) begin
                            launch = 1'b1;              // NEXT_BEAT
                        end else begin
                            state_d = ST_RELEASE;       // SPLIT
                        end
                    end
                    default: ;
                endcase
            end
            ST_RELEASE: begin
                if (ta_n_i) begin
                    if (pend_q) begin                   // REISSUE
                        state_d = ST_ACTIVE;
                        launch  = 1'b1;
                    end else begin                      // QUIET
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_REARB: begin
                if (grant_i) begin                      // REGRANT
                    state_d = ST_ACTIVE;
                    launch  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Transfer context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= OUT_IDLE;
            addr_q   <= '0;
            size_q   <= SZ_WORD;
            tmo_q    <= '0;
            beat_q   <= '0;
            multi_q  <= 1'b0;
            burst_q  <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            if (state_q == ST_IDLE && start_i) begin
                addr_q  <= addr_i;
                size_q  <= size_i;
                tmo_q   <= tmo_load_i;
                beat_q  <= '0;
                multi_q <= burst_req_i && (size_i == SZ_WORD);
                burst_q <= burst_req_i && (size_i == SZ_WORD);
                pend_q  <= 1'b0;
            end else if (active) begin
                if (kind == TK_ERR) begin
                    burst_q <= 1'b0;
                    pend_q  <= 1'b0;
                end else if (kind == TK_ACK) begin
                    if (more) begin
                        beat_q  <= beat_q + 1'b1;
                        addr_q  <= addr_q + STEP;
                        burst_q <= burst_q && bi_n_i;
                        pend_q  <= 1'b1;
                    end else begin
                        burst_q <= 1'b0;
                        pend_q  <= 1'b0;
                    end
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        bus_addr_o  = addr_q;
        beat_cnt_o  = beat_q;
        burst_ok_o  = active && burst_q;
        tea_drive_o = expired;
        rearb_req_o = (state_q == ST_REARB);
        status_o    = status_q;
    end

    assert_status_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != OUT_IDLE) |=> (status_o == OUT_IDLE));

    assert_error_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tea_n_i) |=> (status_o == OUT_ERR && lane_en_o == '0));

    assert_rearb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_req_o && !grant_i) |=> rearb_req_o);

    assert_narrow_no_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && size_i != SZ_WORD) |=> !burst_ok_o);

    assert_ack_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RELEASE && state_q != ST_RELEASE) |-> $past(ta_n_i));

endmodule

// File: tb/bus_term_ctrl_tb.sv
module bus_term_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, burst = 1'b0, ta_n = 1'b1, tea_n = 1'b1;
    logic        retry = 1'b0, bi_n = 1'b1, grant = 1'b0;
    logic [1:0]  size = 2'b10;
    logic [31:0] addr = '0;
    logic [15:0] tmo = 16'd20;
    logic        busy, burst_ok, tea_drive, rearb;
    logic [31:0] bus_addr;
    logic [3:0]  lanes;
    logic [1:0]  beat_cnt, status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_term_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .burst_req_i(burst), .size_i(size),
        .addr_i(addr), .tmo_load_i(tmo), .ta_n_i(ta_n), .tea_n_i(tea_n), .retry_i(retry),
        .bi_n_i(bi_n), .grant_i(grant), .busy_o(busy), .bus_addr_o(bus_addr),
        .lane_en_o(lanes), .beat_cnt_o(beat_cnt), .burst_ok_o(burst_ok),
        .tea_drive_o(tea_drive), .rearb_req_o(rearb), .status_o(status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_lanes(input int sz, input int off);
        int f, w;
        logic [3:0] m;
        f = (sz == 0) ? off : (sz == 1) ? (off & 2) : 0;
        w = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        m = '0;
        for (int p = 0; p < 4; p++) if (p >= f && p < f + w) m[3 - p] = 1'b1;
        return m;
    endfunction

    task automatic launch(input logic [31:0] a, input int sz, input logic b, input int t);
        addr = a; size = 2'(sz); burst = b; tmo = 16'(t); start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic ack_now();
        ta_n = 1'b0;
        tick();
        ta_n = 1'b1;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", 32'(status), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rearb", 32'(rearb), 0);
        chk("R1 lanes", 32'(lanes), 0);
        chk("R1 tea_drive", 32'(tea_drive), 0);
        chk("R1 burst_ok", 32'(burst_ok), 0);

        // R2, R7, R10: single beats over sizes, offsets and burst request
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                for (int b = 0; b < 2; b++) begin
                    if (sz == 2 && b == 1) continue;
                    launch(32'h1000_0000 + 32'(off), sz, b[0], 20);
                    chk("R10 lanes", 32'(lanes), 32'(exp_lanes(sz, off)));
                    chk("R7 burst_ok", 32'(burst_ok), 0);
                    chk("R2 busy", 32'(busy), 1);
                    for (int d = 0; d < off; d++) begin
                        if (d == 0) begin
                            start = 1'b1; addr = 32'h2222_0000;
                        end
                        tick();
                        start = 1'b0;
                        chk("R2 ignored start", bus_addr, 32'h1000_0000 + 32'(off));
                    end
                    bi_n = (sz == 0) ? 1'b0 : 1'b1; // R8 ignored on single
                    ack_now();
                    bi_n = 1'b1;
                    chk("R2 done status", 32'(status), 1);
                    chk("R8 single ignores inhibit", 32'(lanes), 0);
                    tick();
                    chk("R2 status one cycle", 32'(status), 0);
                    chk("R2 idle again", 32'(busy), 0);
                end
            end
        end

        // R4 bus monitor timeout
        for (int l = 0; l < 6; l++) begin
            launch(32'h3000_0000, 2, 1'b0, l);
            for (int n = 0; n <= l; n++) begin
                chk("R4 tea_drive", 32'(tea_drive), (n == l) ? 1 : 0);
                if (n < l) tick();
            end
            tick();
            chk("R4 error status", 32'(status), 2);
            chk("R4 drive dropped", 32'(tea_drive), 0);
            tick();
            chk("R4 idle", 32'(busy), 0);
        end

        // R6, R8, R9, R4 reload: bursts with inhibit at each beat (-1 none)
        for (int inh = -1; inh < 4; inh++) begin
            launch(32'h4000_0010, 2, 1'b1, 3);
            for (int k = 0; k < 4; k++) begin
                chk("R6 address", bus_addr, 32'h4000_0010 + 32'(4 * k));
                chk("R6 beat count", 32'(beat_cnt), 32'(k));
                chk("R8 burst_ok", 32'(burst_ok), (inh < 0 || k <= inh) ? 1 : 0);
                chk("R6 lanes", 32'(lanes), 32'hF);
                tick();
                tick();
                chk("R4 reload no timeout", 32'(tea_drive), 0);
                ta_n = 1'b0;
                bi_n = (k == inh) ? 1'b0 : 1'b1;
                tick();
                bi_n = 1'b1;
                if (k == 3) begin
                    ta_n = 1'b1;
                    chk("R6 done once", 32'(status), 1);
                    tick();
                    chk("R6 idle", 32'(busy), 0);
                end else if (inh >= 0 && k >= inh) begin
                    chk("R8 split release", 32'(lanes), 0);
                    chk("R8 no status", 32'(status), 0);
                    if (k == inh) begin
                        tick(); // acknowledge still low
                        chk("R9 held off", 32'(lanes), 0);
                        chk("R9 busy", 32'(busy), 1);
                    end
                    ta_n = 1'b1;
                    tick();
                end else begin
                    ta_n = 1'b1;
                    chk("R6 no early status", 32'(status), 0);
                end
            end
        end

        // R5 retry at beat rb of a burst, grant after g cycles
        for (int rb = 0; rb < 3; rb++) begin
            for (int g = 0; g < 3; g++) begin
                launch(32'h5000_0000, 2, 1'b1, 10);
                for (int k = 0; k < rb; k++) ack_now();
                retry = 1'b1; ta_n = 1'b0;
                tick();
                retry = 1'b0; ta_n = 1'b1;
                chk("R5 retry status", 32'(status), 3);
                chk("R5 rearb", 32'(rearb), 1);
                chk("R5 off bus", 32'(lanes), 0);
                for (int j = 0; j < g; j++) begin
                    tick();
                    chk("R5 rearb held", 32'(rearb), 1);
                end
                grant = 1'b1;
                tick();
                grant = 1'b0;
                chk("R5 rearb dropped", 32'(rearb), 0);
                chk("R5 same address", bus_addr, 32'h5000_0000 + 32'(4 * rb));
                chk("R5 same beat", 32'(beat_cnt), 32'(rb));
                chk("R5 burst kept", 32'(burst_ok), 1);
                for (int k = rb; k < 4; k++) ack_now();
                chk("R5 done after rerun", 32'(status), 1);
                tick();
            end
        end

        // R3 error wins over acknowledge and retry, aborts the rest
        for (int eb = 0; eb < 4; eb++) begin
            launch(32'h6000_0000, 2, 1'b1, 10);
            for (int k = 0; k < eb; k++) ack_now();
            tea_n = 1'b0; ta_n = 1'b0; retry = 1'b1;
            chk("R3 monitor not driving", 32'(tea_drive), 0);
            tick();
            tea_n = 1'b1; ta_n = 1'b1; retry = 1'b0;
            chk("R3 error status", 32'(status), 2);
            chk("R3 no more beats", 32'(lanes), 0);
            chk("R3 no rearb", 32'(rearb), 0);
            tick();
            chk("R3 idle", 32'(busy), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule